// File: doc/BRIEF.md
# Bus signature analysis unit

This unit watches two buses inside a chip and folds every sampled word into a 32-bit running signature. Self-test software seeds a signature, lets a known stretch of activity run, and then compares the result with a precomputed value. Channel 1 watches a program-address bus and always compresses with a fixed multiple-input shift register. Channel 2 watches a data-write bus, and a two-bit mode field picks one of four compression functions for it.

Each channel has its own state machine with four states: `CH_HALT_CYCLE`, `CH_HALT_EVENT`, `CH_RUN_CYCLE` and `CH_RUN_EVENT`. The state holds both the run/halt choice and the per-cycle/per-event choice. The only transition happens on a write to the control word. From any state, that write moves the machine to the state given by the written run bit and event bit. With no such write, the machine stays where it is.

In a RUN state the signature updates. `CH_RUN_CYCLE` updates on every clock. `CH_RUN_EVENT` updates only when the bus valid strobe is high. In a HALT state the signature holds its value. A small register port gives access to the control word and to both signature registers. Through it, software can seed a signature or clear it.

Top module: `bus_sig_unit`

## Requirements
- R1: After reset, the control word reads 0 and both signature registers read 0.
- R2: While a channel's run bit is 0, its signature keeps its value whatever the bus does.
- R3: While a channel runs with its event bit at 0, the signature updates at every clock edge. With the event bit at 1, it updates only at edges where that bus's valid strobe is 1.
- R4: Writing 1 to a clear bit sets that channel's signature to 0 at the write edge. A clear wins over a bus update in the same cycle. Writing 0 to a clear bit has no effect, and a clear bit always reads back 0.
- R5: A write to a signature address loads the written 32-bit seed. The seed wins over a bus update in the same cycle. Both signatures can be read at any time.
- R6: Channel 1 updates as next = (sig<<1) XOR (sig[31] ? 0x0020_0007 : 0) XOR word.
- R7: Channel 2 mode 00 uses the same step as R6. Mode 01 is CRC32 with polynomial 0x04C11DB7, processing the word one byte at a time starting with the least significant byte, each byte MSB first, with no reflection and no final XOR.
- R8: Channel 2 mode 10 is CRC16 with polynomial 0x8005, and mode 11 is CRC16 with polynomial 0x1021. Both work on the low 16 bits, in the same byte order as R7. Bits 31:16 of the result are 0.
- R9: Register address 0 is the control word, address 1 is signature 1, address 2 is signature 2, and address 3 reads 0. The control word layout is: bit 0 run 1, bit 1 event 1, bit 2 run 2, bit 3 event 2, bit 4 clear 1, bit 5 clear 2, bits 7:6 mode. Bits 31:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| pab_data | input | 32 | Program-address bus word (channel 1) |
| pab_valid | input | 1 | Program-address bus event strobe |
| dwb_data | input | 32 | Data-write bus word (channel 2) |
| dwb_valid | input | 1 | Data-write bus event strobe |

## Verification
The hardest cases to reach are the priority cases. In each of them, a clear or a seed lands on an edge where the running channel would also have updated. The bench puts the channel in `CH_RUN_CYCLE` with bus traffic active, so that every edge carries an update. It then issues the clear or the seed write and reads the register on the next falling edge, before another update can hide the result. All four modes are swept under both the per-cycle and the per-event setting. The valid strobes toggle pseudo-randomly, so that per-event compression both skips and takes words.

// File: rtl/bsu_pkg.sv
package bsu_pkg;
    localparam int SIG_W   = 32;
    localparam int ADDR_W  = 2;
    localparam int BYTES_W = SIG_W / 8;

    localparam logic [SIG_W-1:0] MISR_TAPS = 32'h0020_0007;
    localparam logic [SIG_W-1:0] POLY_C32  = 32'h04C1_1DB7;
    localparam logic [SIG_W-1:0] POLY_C16A = 32'h0000_8005;
    localparam logic [SIG_W-1:0] POLY_C16B = 32'h0000_1021;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_SIG1 = 2'd1;
    localparam logic [ADDR_W-1:0] A_SIG2 = 2'd2;

    localparam int CB_RUN1 = 0;
    localparam int CB_EVT1 = 1;
    localparam int CB_RUN2 = 2;
    localparam int CB_EVT2 = 3;
    localparam int CB_CLR1 = 4;
    localparam int CB_CLR2 = 5;
    localparam int CB_MODE = 6;

    typedef enum logic [1:0] {
        MODE_MISR  = 2'b00,
        MODE_C32   = 2'b01,
        MODE_C16A  = 2'b10,
        MODE_C16B  = 2'b11
    } sig_mode_e;

    typedef enum logic [1:0] {
        CH_HALT_CYCLE = 2'b00,
        CH_HALT_EVENT = 2'b01,
        CH_RUN_CYCLE  = 2'b10,
        CH_RUN_EVENT  = 2'b11
    } ch_state_e;

    function automatic logic [SIG_W-1:0] misr_step(
        input logic [SIG_W-1:0] s,
        input logic [SIG_W-1:0] d
    );
        logic [SIG_W-1:0] n;
        n = {s[SIG_W-2:0], 1'b0};
        if (s[SIG_W-1]) n = n ^ MISR_TAPS;
        return n ^ d;
    endfunction

    function automatic logic [SIG_W-1:0] crc_word(
        input logic [SIG_W-1:0] c,
        input logic [SIG_W-1:0] d,
        input logic [SIG_W-1:0] poly,
        input logic             narrow
    );
        logic [SIG_W-1:0] r;
        logic             top;
        r = narrow ? {16'h0000, c[15:0]} : c;
        for (int b = 0; b < BYTES_W; b++) begin
            if (narrow) r[15:8]  = r[15:8]  ^ d[8*b +: 8];
            else        r[31:24] = r[31:24] ^ d[8*b +: 8];
            for (int k = 0; k < 8; k++) begin
                top = narrow ? r[15] : r[31];
                r   = {r[SIG_W-2:0], 1'b0};
                if (top) r = r ^ poly;
                if (narrow) r[31:16] = 16'h0000;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/bsu_ctrl.sv
module bsu_ctrl
    import bsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [SIG_W-1:0]  wdata_i,
    input  logic [SIG_W-1:0]  sig1_i,
    input  logic [SIG_W-1:0]  sig2_i,
    input  logic              run1_i,
    input  logic              evt1_i,
    input  logic              run2_i,
    input  logic              evt2_i,
    output logic [SIG_W-1:0]  rdata_o,
    output logic              ctrl_wr_o,
    output logic              run1_wr_o,
    output logic              evt1_wr_o,
    output logic              run2_wr_o,
    output logic              evt2_wr_o,
    output logic              clr1_o,
    output logic              clr2_o,
    output logic              seed1_o,
    output logic              seed2_o,
    output sig_mode_e         mode_o
);
    sig_mode_e mode_q;

    assign ctrl_wr_o = wr_en_i && (addr_i == A_CTRL);
    assign seed1_o   = wr_en_i && (addr_i == A_SIG1);
    assign seed2_o   = wr_en_i && (addr_i == A_SIG2);
    assign run1_wr_o = wdata_i[CB_RUN1];
    assign evt1_wr_o = wdata_i[CB_EVT1];
    assign run2_wr_o = wdata_i[CB_RUN2];
    assign evt2_wr_o = wdata_i[CB_EVT2];
    assign clr1_o    = ctrl_wr_o && wdata_i[CB_CLR1];
    assign clr2_o    = ctrl_wr_o && wdata_i[CB_CLR2];
    assign mode_o    = mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mode_q <= MODE_MISR;
        else if (ctrl_wr_o) mode_q <= sig_mode_e'(wdata_i[CB_MODE +: 2]);
    end

    always_comb begin
        case (addr_i)
            A_CTRL:  rdata_o = {24'h0, mode_q, 2'b00, evt2_i, run2_i, evt1_i, run1_i};
            A_SIG1:  rdata_o = sig1_i;
            A_SIG2:  rdata_o = sig2_i;
            default: rdata_o = '0;
        endcase
    end

    // R7: mode only changes through a control write
    assert_mode_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_wr_o |=> mode_q == $past(mode_q));
endmodule

// File: rtl/bsu_channel.sv
module bsu_channel
    import bsu_pkg::*;
#(
    parameter bit SELECTABLE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr_i,
    input  logic             run_wr_i,
    input  logic             evt_wr_i,
    input  logic             clr_i,
    input  logic             seed_wr_i,
    input  logic [SIG_W-1:0] seed_i,
    input  sig_mode_e        mode_i,
    input  logic [SIG_W-1:0] bus_data_i,
    input  logic             bus_valid_i,
    output logic [SIG_W-1:0] sig_o,
    output logic             run_o,
    output logic             evt_o
);
    ch_state_e        state_q, state_d;
    logic             upd_en;
    logic [SIG_W-1:0] sig_q, step;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_HALT_CYCLE;
        else        state_q <= state_d;
    end

    // transitions: a control write picks the state from its run/event bits
    always_comb begin
        state_d = state_q;
        if (ctrl_wr_i) begin
            unique case ({run_wr_i, evt_wr_i})
                2'b00: state_d = CH_HALT_CYCLE;
                2'b01: state_d = CH_HALT_EVENT;
                2'b10: state_d = CH_RUN_CYCLE;
                2'b11: state_d = CH_RUN_EVENT;
            endcase
        end
    end

    // outputs of the state machine
    always_comb begin
        unique case (state_q)
            CH_HALT_CYCLE: begin upd_en = 1'b0;        run_o = 1'b0; evt_o = 1'b0; end
            CH_HALT_EVENT: begin upd_en = 1'b0;        run_o = 1'b0; evt_o = 1'b1; end
            CH_RUN_CYCLE:  begin upd_en = 1'b1;        run_o = 1'b1; evt_o = 1'b0; end
            CH_RUN_EVENT:  begin upd_en = bus_valid_i; run_o = 1'b1; evt_o = 1'b1; end
        endcase
    end

    generate
        if (SELECTABLE) begin : g_sel
            always_comb begin
                unique case (mode_i)
                    MODE_MISR: step = misr_step(sig_q, bus_data_i);
                    MODE_C32:  step = crc_word(sig_q, bus_data_i, POLY_C32, 1'b0);
                    MODE_C16A: step = crc_word(sig_q, bus_data_i, POLY_C16A, 1'b1);
                    MODE_C16B: step = crc_word(sig_q, bus_data_i, POLY_C16B, 1'b1);
                endcase
            end
            // R8: narrow CRC results keep the upper half at zero
            assert_narrow_upper_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (upd_en && !clr_i && !seed_wr_i && mode_i[1]) |=> sig_q[31:16] == 16'h0);
        end else begin : g_fixed
            logic unused_mode;
            assign unused_mode = ^mode_i;
            always_comb step = misr_step(sig_q, bus_data_i);
        end
    endgenerate

    // signature register: clear, then seed, then bus update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sig_q <= '0;
        else if (clr_i)     sig_q <= '0;
        else if (seed_wr_i) sig_q <= seed_i;
        else if (upd_en)    sig_q <= step;
    end

    assign sig_o = sig_q;

    // R4: a clear leaves the signature at zero
    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> sig_q == '0);
    // R5: a seed write without a clear loads the seed
    assert_seed_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_wr_i && !clr_i) |=> sig_q == $past(seed_i));
    // R2: halted channels hold
    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !clr_i && !seed_wr_i) |=> sig_q == $past(sig_q));
    // R3: event mode ignores cycles without a valid strobe
    assert_event_skip_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !bus_valid_i && !clr_i && !seed_wr_i) |=> sig_q == $past(sig_q));
endmodule

// File: rtl/bus_sig_unit.sv
module bus_sig_unit
    import bsu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] pab_data,
    input  logic        pab_valid,
    input  logic [31:0] dwb_data,
    input  logic        dwb_valid
);
    logic             ctrl_wr, run1_wr, evt1_wr, run2_wr, evt2_wr;
    logic             clr1, clr2, seed1, seed2;
    logic             run1, evt1, run2, evt2;
    logic [SIG_W-1:0] sig1, sig2;
    sig_mode_e        mode;

    bsu_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (reg_wr_en),
        .addr_i    (reg_addr),
        .wdata_i   (reg_wdata),
        .sig1_i    (sig1),
        .sig2_i    (sig2),
        .run1_i    (run1),
        .evt1_i    (evt1),
        .run2_i    (run2),
        .evt2_i    (evt2),
        .rdata_o   (reg_rdata),
        .ctrl_wr_o (ctrl_wr),
        .run1_wr_o (run1_wr),
        .evt1_wr_o (evt1_wr),
        .run2_wr_o (run2_wr),
        .evt2_wr_o (evt2_wr),
        .clr1_o    (clr1),
        .clr2_o    (clr2),
        .seed1_o   (seed1),
        .seed2_o   (seed2),
        .mode_o    (mode)
    );

    bsu_channel #(.SELECTABLE(1'b0)) u_ch1 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (ctrl_wr),
        .run_wr_i    (run1_wr),
        .evt_wr_i    (evt1_wr),
        .clr_i       (clr1),
        .seed_wr_i   (seed1),
        .seed_i      (reg_wdata),
        .mode_i      (MODE_MISR),
        .bus_data_i  (pab_data),
        .bus_valid_i (pab_valid),
        .sig_o       (sig1),
        .run_o       (run1),
        .evt_o       (evt1)
    );

    bsu_channel #(.SELECTABLE(1'b1)) u_ch2 (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_wr_i   (ctrl_wr),
        .run_wr_i    (run2_wr),
        .evt_wr_i    (evt2_wr),
        .clr_i       (clr2),
        .seed_wr_i   (seed2),
        .seed_i      (reg_wdata),
        .mode_i      (mode),
        .bus_data_i  (dwb_data),
        .bus_valid_i (dwb_valid),
        .sig_o       (sig2),
        .run_o       (run2),
        .evt_o       (evt2)
    );

    // R9: the run/event readback follows the last control write
    assert_ctrl_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (run1 == $past(reg_wdata[CB_RUN1])) && (evt2 == $past(reg_wdata[CB_EVT2])));
endmodule

// File: tb/bus_sig_unit_test.sv
`timescale 1ns/1ps
module bus_sig_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic [31:0] pab_data = 32'h0;
    logic        pab_valid = 1'b0;
    logic [31:0] dwb_data = 32'h0;
    logic        dwb_valid = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    bit drive_en = 1'b0;
    logic [31:0] xs = 32'h1357_9BDF;

    // shadow model state
    logic        s_run1 = 0, s_evt1 = 0, s_run2 = 0, s_evt2 = 0;
    logic [1:0]  s_mode = 0;
    logic [31:0] m1 = 0, m2 = 0, n1, n2;

    always #2.5 clk = ~clk;

    bus_sig_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pab_data(pab_data),
        .pab_valid(pab_valid), .dwb_data(dwb_data), .dwb_valid(dwb_valid)
    );

    function automatic logic [31:0] ref_misr(logic [31:0] s, logic [31:0] d);
        return ({s[30:0], 1'b0} ^ (s[31] ? 32'h0020_0007 : 32'h0)) ^ d;
    endfunction

    // bit-serial CRC: feedback bit = register top XOR incoming data bit
    function automatic logic [31:0] ref_crc(logic [31:0] c, logic [31:0] d,
                                            logic [31:0] p, int w);
        logic [31:0] r;
        logic fb;
        r = (w == 16) ? (c & 32'h0000_FFFF) : c;
        for (int b = 0; b < 4; b++) begin
            for (int i = 7; i >= 0; i--) begin
                fb = r[w-1] ^ d[8*b + i];
                r = r << 1;
                if (fb) r = r ^ p;
                if (w == 16) r = r & 32'h0000_FFFF;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] ref_ch2(logic [31:0] s, logic [31:0] d, logic [1:0] m);
        case (m)
            2'b00:   return ref_misr(s, d);
            2'b01:   return ref_crc(s, d, 32'h04C1_1DB7, 32);
            2'b10:   return ref_crc(s, d, 32'h0000_8005, 16);
            default: return ref_crc(s, d, 32'h0000_1021, 16);
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m1 = 0; m2 = 0; s_run1 = 0; s_evt1 = 0; s_run2 = 0; s_evt2 = 0; s_mode = 0;
        end else begin
            n1 = m1; n2 = m2;
            if (s_run1 && (!s_evt1 || pab_valid)) n1 = ref_misr(m1, pab_data);
            if (s_run2 && (!s_evt2 || dwb_valid)) n2 = ref_ch2(m2, dwb_data, s_mode);
            if (reg_wr_en && reg_addr == 2'd1) n1 = reg_wdata;
            if (reg_wr_en && reg_addr == 2'd2) n2 = reg_wdata;
            if (reg_wr_en && reg_addr == 2'd0) begin
                if (reg_wdata[4]) n1 = 0;
                if (reg_wdata[5]) n2 = 0;
                s_run1 = reg_wdata[0]; s_evt1 = reg_wdata[1];
                s_run2 = reg_wdata[2]; s_evt2 = reg_wdata[3];
                s_mode = reg_wdata[7:6];
            end
            m1 = n1; m2 = n2;
        end
    end

    // bus stimulus: xorshift words, valid strobes from its bits
    always @(negedge clk) begin
        if (drive_en) begin
            xs = xs ^ (xs << 13);
            xs = xs ^ (xs >> 17);
            xs = xs ^ (xs << 5);
            pab_data  = xs;
            dwb_data  = {xs[15:0], xs[31:16]} ^ 32'hA5C3_0F96;
            pab_valid = xs[3];
            dwb_valid = xs[9];
        end
    end

    task automatic check_read(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%08h expected=%08h", tag, a, reg_rdata, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctrl_exp();
        return {24'h0, s_mode, 2'b00, s_evt2, s_run2, s_evt1, s_run1};
    endfunction

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_read(2'd0, 32'h0, "R1 ctrl");
        check_read(2'd1, 32'h0, "R1 sig1");
        check_read(2'd2, 32'h0, "R1 sig2");
        check_read(2'd3, 32'h0, "R9 unmapped");

        // R9/R4: all bits written, clears read back 0, reserved read 0
        reg_write(2'd0, 32'hFFFF_FFFF);
        check_read(2'd0, 32'h0000_00CF, "R9 ctrl layout R4 clear reads 0");
        reg_write(2'd0, 32'h0000_0000);
        check_read(2'd0, 32'h0, "R9 ctrl halt");

        // R5 seeds, R2 hold while halted with busy buses
        reg_write(2'd1, 32'h1234_5678);
        reg_write(2'd2, 32'h9ABC_DEF0);
        drive_en = 1'b1;
        repeat (20) @(negedge clk);
        check_read(2'd1, 32'h1234_5678, "R2 R5 sig1 hold");
        check_read(2'd2, 32'h9ABC_DEF0, "R2 R5 sig2 hold");
        // R4: clear bits at 0 in a control write leave signatures unchanged
        reg_write(2'd0, 32'h0000_00C0);
        check_read(2'd1, 32'h1234_5678, "R4 zero-clear ignored sig1");
        check_read(2'd2, 32'h9ABC_DEF0, "R4 zero-clear ignored sig2");

        // R3 R6 R7 R8: sweep modes and cycle/event settings
        for (int md = 0; md < 4; md++) begin
            for (int ev = 0; ev < 2; ev++) begin
                reg_write(2'd1, 32'hC0DE_0000 | md);
                reg_write(2'd2, 32'hFACE_B000 | (ev << 4) | md);
                reg_write(2'd0, (md << 6) | (ev << 3) | 32'h4 | (ev << 1) | 32'h1);
                for (int c = 0; c < 20; c++) begin
                    @(negedge clk);
                    check_read(2'd1, m1, ev ? "R3 R6 ch1 event" : "R3 R6 ch1 cycle");
                    check_read(2'd2, m2, md == 1 ? "R7 crc32" : md == 0 ? "R7 misr" : "R8 crc16");
                end
                reg_write(2'd0, (md << 6));
                check_read(2'd2, m2, "R2 ch2 after halt");
            end
        end

        // R4: clear wins over an update on the same edge
        reg_write(2'd0, 32'h0000_0045);
        repeat (5) @(negedge clk);
        reg_write(2'd0, 32'h0000_0075);
        check_read(2'd1, 32'h0, "R4 clear beats update ch1");
        check_read(2'd2, 32'h0, "R4 clear beats update ch2");
        @(negedge clk);
        check_read(2'd1, m1, "R6 resumes after clear");
        check_read(2'd2, m2, "R7 resumes after clear");

        // R5: seed wins over an update on the same edge
        reg_write(2'd2, 32'h5EED_0042);
        check_read(2'd2, 32'h5EED_0042, "R5 seed beats update ch2");
        reg_write(2'd1, 32'h5EED_1111);
        check_read(2'd1, 32'h5EED_1111, "R5 seed beats update ch1");
        check_read(2'd0, ctrl_exp(), "R9 ctrl while running");
        reg_write(2'd0, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule